// File: doc/BRIEF.md
# Nibble-Wide MAC Transmit Sequencer

This block sits between a frame assembler and a 4-bit physical-layer transmit interface. It emits one nibble per clock. A start pulse from the defer controller opens a frame. The block then sends fourteen preamble nibbles and the two nibbles of the start-of-frame delimiter. After that it sends the assembler's bytes, two clocks per byte, and ends with the 32-bit frame check sequence. Transmit-valid is high for every nibble of the frame. A one-cycle transmit-over pulse marks a clean end.

A collision changes the ending. A collision seen while the preamble is on the wire is remembered, and the preamble runs to its last nibble. The block then sends a 32-bit jam instead of the delimiter. A collision seen at any later point cuts the frame at once and starts the jam on the next nibble. In both cases start-backoff pulses with the first jam nibble, the assembler enable drops, and transmit-valid falls after the eighth jam nibble.

Top module: `mac_nibble_tx`

## Requirements
- R1: While reset is asserted (asynchronous, active low), every output is zero, including when reset arrives in the middle of a frame.
- R2: A start pulse sampled in idle puts nibble 0x5 on the wire in the next cycle with transmit-valid high. The first 14 nibbles are 0x5, followed by 0x5 and then 0xD, which is the delimiter byte 0xD5 sent low nibble first.
- R3: A start pulse sampled while a frame or jam is in progress has no effect on the nibble stream.
- R4: The assembler enable is high from the delimiter's high-nibble cycle through the low-nibble cycle of the last byte. A byte is taken at each clock edge that ends a cycle where the enable is high and the wire carries a high nibble (the delimiter or a data byte). The eof flag taken with a byte marks it as the last byte. Each byte goes out low nibble first.
- R5: After the last data nibble, the FCS value taken at that edge is sent as 8 nibbles, least significant nibble first.
- R6: In the cycle after the last FCS nibble, transmit-valid and the enable are low, the nibble is 0, and transmit-over is high for exactly that one cycle.
- R7: A collision sampled while a preamble nibble is on the wire lets all 14 preamble nibbles go out. It is followed by 8 nibbles of 0xA, and the delimiter is not sent.
- R8: A collision sampled while a delimiter, data or FCS nibble is on the wire makes the very next nibble the first of 8 jam nibbles of 0xA.
- R9: Start-backoff is high for exactly the first jam nibble, with the enable low. Collisions during the jam are ignored. Transmit-valid drops after the eighth jam nibble, and no transmit-over follows.
- R10: Whenever transmit-valid is low the nibble is 0, and a collision while idle causes no output activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request from the defer controller |
| asm_byte_i | input | 8 | Next frame byte from the assembler |
| asm_eof_i | input | 1 | The presented byte is the last one |
| fcs_i | input | FCS_W | Frame check value, sampled when the last data nibble ends |
| coll_i | input | 1 | Collision detect from the physical layer |
| txd_o | output | 4 | Transmit nibble |
| tx_en_o | output | 1 | Transmit-valid |
| asm_en_o | output | 1 | Assembler enable |
| tx_done_o | output | 1 | One-cycle pulse at the end of a clean frame |
| backoff_o | output | 1 | One-cycle start-backoff request |

## Verification
Every output is registered. Nibble index 0 is due in the first cycle after the edge that samples start. A collision sampled at the edge ending nibble index i shows up as jam at index i+1, or at index 14 when i falls in the preamble. Transmit-over or the fall of transmit-valid is due one cycle after the last nibble. The bench computes the full expected stream from these rules and drives every input at the falling edge. It compares all five outputs at each falling edge, so every result is checked in the exact cycle it is due.

// File: rtl/nibtx_pkg.sv
package nibtx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_FCS,
        ST_JAM
    } tx_state_e;
endpackage

// File: rtl/nibtx_fcs_shift.sv
module nibtx_fcs_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] din_i,
    output logic [3:0]   nxt_o
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= din_i;
        end else if (shift_i) begin
            sh_q <= {4'b0000, sh_q[W-1:4]};
        end
    end

    // nibble that follows the one currently on the wire
    assign nxt_o = sh_q[7:4];
endmodule

// File: rtl/mac_nibble_tx.sv
module mac_nibble_tx
    import nibtx_pkg::*;
#(
    parameter int         PRE_NIB = 14,
    parameter int         JAM_NIB = 8,
    parameter int         FCS_W   = 32,
    parameter logic [3:0] PRE_VAL = 4'h5,
    parameter logic [3:0] SFD_LO  = 4'h5,
    parameter logic [3:0] SFD_HI  = 4'hD,
    parameter logic [3:0] JAM_VAL = 4'hA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       asm_byte_i,
    input  logic             asm_eof_i,
    input  logic [FCS_W-1:0] fcs_i,
    input  logic             coll_i,
    output logic [3:0]       txd_o,
    output logic             tx_en_o,
    output logic             asm_en_o,
    output logic             tx_done_o,
    output logic             backoff_o
);
    localparam int FCS_NIB = FCS_W / 4;
    localparam int HDR_NIB = PRE_NIB + 2;
    localparam int CNT_W   = $clog2(HDR_NIB + FCS_NIB + JAM_NIB + 1);

    typedef struct packed {
        tx_state_e  st;
        logic [CNT_W-1:0] cnt;
        logic [7:0] dat;
        logic       last;
        logic       pend;
        logic [3:0] txd;
        logic       txen;
        logic       asmen;
        logic       done;
        logic       bo;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_IDLE, default: '0};

    seq_t seq_d, seq_q;
    logic fcs_load, fcs_shift;
    logic [3:0] fcs_nxt;
    logic go_jam, pend_now;

    nibtx_fcs_shift #(.W(FCS_W)) u_fcs (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (fcs_load),
        .shift_i(fcs_shift),
        .din_i  (fcs_i),
        .nxt_o  (fcs_nxt)
    );

    always_comb begin
        seq_d     = seq_q;
        seq_d.done = 1'b0;
        seq_d.bo   = 1'b0;
        fcs_load  = 1'b0;
        fcs_shift = 1'b0;
        go_jam    = 1'b0;
        pend_now  = seq_q.pend | coll_i;

        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st    = ST_HDR;
                    seq_d.cnt   = CNT_W'(1);
                    seq_d.txd   = PRE_VAL;
                    seq_d.txen  = 1'b1;
                    seq_d.pend  = 1'b0;
                    seq_d.asmen = 1'b0;
                end
            end
            ST_HDR: begin
                if (seq_q.cnt <= CNT_W'(PRE_NIB)) begin
                    // preamble on the wire: a collision is only remembered
                    if (seq_q.cnt == CNT_W'(PRE_NIB)) begin
                        if (pend_now) begin
                            go_jam = 1'b1;
                        end else begin
                            seq_d.txd = SFD_LO;
                            seq_d.cnt = seq_q.cnt + 1'b1;
                        end
                    end else begin
                        seq_d.pend = pend_now;
                        seq_d.txd  = PRE_VAL;
                        seq_d.cnt  = seq_q.cnt + 1'b1;
                    end
                end else if (coll_i) begin
                    go_jam = 1'b1;
                end else if (seq_q.cnt == CNT_W'(PRE_NIB + 1)) begin
                    seq_d.txd   = SFD_HI;
                    seq_d.cnt   = seq_q.cnt + 1'b1;
                    seq_d.asmen = 1'b1;
                end else begin
                    seq_d.st    = ST_DATA;
                    seq_d.dat   = asm_byte_i;
                    seq_d.last  = asm_eof_i;
                    seq_d.txd   = asm_byte_i[3:0];
                    seq_d.cnt   = CNT_W'(1);
                    seq_d.asmen = 1'b1;
                end
            end
            ST_DATA: begin
                if (coll_i) begin
                    go_jam = 1'b1;
                end else if (seq_q.cnt == CNT_W'(1)) begin
                    seq_d.txd   = seq_q.dat[7:4];
                    seq_d.cnt   = '0;
                    seq_d.asmen = !seq_q.last;
                end else if (seq_q.last) begin
                    seq_d.st    = ST_FCS;
                    fcs_load    = 1'b1;
                    seq_d.txd   = fcs_i[3:0];
                    seq_d.cnt   = CNT_W'(1);
                    seq_d.asmen = 1'b0;
                end else begin
                    seq_d.dat   = asm_byte_i;
                    seq_d.last  = asm_eof_i;
                    seq_d.txd   = asm_byte_i[3:0];
                    seq_d.cnt   = CNT_W'(1);
                    seq_d.asmen = 1'b1;
                end
            end
            ST_FCS: begin
                if (coll_i) begin
                    go_jam = 1'b1;
                end else if (seq_q.cnt == CNT_W'(FCS_NIB)) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.txd  = '0;
                    seq_d.txen = 1'b0;
                    seq_d.done = 1'b1;
                    seq_d.cnt  = '0;
                end else begin
                    seq_d.txd = fcs_nxt;
                    fcs_shift = 1'b1;
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_JAM: begin
                if (seq_q.cnt == CNT_W'(JAM_NIB)) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.txd  = '0;
                    seq_d.txen = 1'b0;
                    seq_d.cnt  = '0;
                end else begin
                    seq_d.txd = JAM_VAL;
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d = SEQ_RST;
        endcase

        if (go_jam) begin
            seq_d.st    = ST_JAM;
            seq_d.cnt   = CNT_W'(1);
            seq_d.txd   = JAM_VAL;
            seq_d.asmen = 1'b0;
            seq_d.bo    = 1'b1;
            seq_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign txd_o     = seq_q.txd;
    assign tx_en_o   = seq_q.txen;
    assign asm_en_o  = seq_q.asmen;
    assign tx_done_o = seq_q.done;
    assign backoff_o = seq_q.bo;
endmodule

// File: rtl/nibtx_checker.sv
module nibtx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [3:0] txd_o,
    input logic       tx_en_o,
    input logic       asm_en_o,
    input logic       tx_done_o,
    input logic       backoff_o
);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_o |-> txd_o == 4'h0);

    assert_enable_inside_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        asm_en_o |-> tx_en_o);

    assert_done_closes_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_o |-> !tx_en_o && !asm_en_o && $past(tx_en_o));

    assert_backoff_on_jam_R9: assert property (@(posedge clk) disable iff (!rst_n)
        backoff_o |-> tx_en_o && txd_o == 4'hA && !asm_en_o);

    assert_backoff_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        backoff_o |=> !backoff_o);

    assert_frame_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en_o) |-> txd_o == 4'h5 && $past(start_i));
endmodule

bind mac_nibble_tx nibtx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .txd_o    (txd_o),
    .tx_en_o  (tx_en_o),
    .asm_en_o (asm_en_o),
    .tx_done_o(tx_done_o),
    .backoff_o(backoff_o)
);

// File: tb/mac_nibble_tx_bench.sv
`timescale 1ns/1ps
module mac_nibble_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  asm_byte_i;
    logic        asm_eof_i;
    logic [31:0] fcs_i = '0;
    logic        coll_i = 1'b0;
    logic [3:0]  txd_o;
    logic        tx_en_o, asm_en_o, tx_done_o, backoff_o;

    int n_chk = 0;
    int n_fail = 0;
    int cur_len = 1;
    int cur_seed = 0;
    int en_cnt = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    mac_nibble_tx u_mac_nibble_tx (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .asm_byte_i(asm_byte_i), .asm_eof_i(asm_eof_i), .fcs_i(fcs_i),
        .coll_i(coll_i), .txd_o(txd_o), .tx_en_o(tx_en_o),
        .asm_en_o(asm_en_o), .tx_done_o(tx_done_o), .backoff_o(backoff_o)
    );

    function automatic logic [7:0] dbyte(int idx, int seed);
        return 8'((idx * 37 + seed * 11 + 3) & 255);
    endfunction

    // assembler model: a byte index advances every two enabled cycles
    always @(posedge clk) en_cnt <= tx_en_o ? en_cnt + (asm_en_o ? 1 : 0) : 0;
    always_comb begin
        asm_byte_i = dbyte(en_cnt >> 1, cur_seed);
        asm_eof_i  = ((en_cnt >> 1) == cur_len - 1);
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements): got hang expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input string req, input int idx, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s idx %0d: got %h expected %h (txd,en,asm,bo,done)", req, idx, act, exp);
        end
    endtask

    function automatic logic [3:0] norm_nib(int i, int len, int seed, logic [31:0] fcs);
        logic [7:0] b;
        if (i < 15) return 4'h5;
        if (i == 15) return 4'hD;
        if (i < 16 + 2 * len) begin
            b = dbyte((i - 16) / 2, seed);
            return ((i - 16) % 2) ? b[7:4] : b[3:0];
        end
        return fcs[4 * (i - 16 - 2 * len) +: 4];
    endfunction

    typedef struct packed {
        logic [7:0]  len;
        logic [7:0]  coll_at;
        logic        hold;
        logic        restart;
        logic [31:0] fcs;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{len: 8'd1, coll_at: 8'd255, hold: 1'b0, restart: 1'b0, fcs: 32'h1234_5678},
        '{len: 8'd5, coll_at: 8'd255, hold: 1'b0, restart: 1'b1, fcs: 32'hDEAD_BEEF},
        '{len: 8'd3, coll_at: 8'd5,   hold: 1'b0, restart: 1'b0, fcs: 32'h0F0F_0F0F},
        '{len: 8'd3, coll_at: 8'd13,  hold: 1'b0, restart: 1'b0, fcs: 32'hCAFE_0001},
        '{len: 8'd3, coll_at: 8'd14,  hold: 1'b0, restart: 1'b0, fcs: 32'h8765_4321},
        '{len: 8'd4, coll_at: 8'd19,  hold: 1'b0, restart: 1'b0, fcs: 32'h1111_2222},
        '{len: 8'd2, coll_at: 8'd23,  hold: 1'b0, restart: 1'b0, fcs: 32'hA5A5_5A5A},
        '{len: 8'd2, coll_at: 8'd2,   hold: 1'b1, restart: 1'b0, fcs: 32'h0000_FFFF}
    };

    function automatic string tag(int i, int len, int cut, bit collided, bit pre_coll, bit restart, int n);
        if (i == n) return collided ? "R9" : "R6";
        if (collided && i == cut + 1) return "R9";
        if (collided && i > cut) return pre_coll ? "R7" : "R8";
        if (restart && i >= 20) return "R3";
        if (i < 16) return "R2";
        if (i < 16 + 2 * len) return "R4";
        return "R5";
    endfunction

    task automatic run_vec(input int vi);
        vec_t v;
        int len, norm_n, cut, n;
        bit collided, pre_coll;
        logic [7:0] exp;
        v = VECS[vi];
        len = int'(v.len);
        cur_len = len; cur_seed = vi; fcs_i = v.fcs;
        norm_n = 16 + 2 * len + 8;
        collided = (int'(v.coll_at) < norm_n);
        pre_coll = collided && (int'(v.coll_at) < 14);
        cut = pre_coll ? 13 : int'(v.coll_at);
        n = collided ? cut + 9 : norm_n;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int i = 0; i <= n; i++) begin
            if (i < n) begin
                exp[7:4] = (collided && i > cut) ? 4'hA : norm_nib(i, len, vi, v.fcs);
                exp[3]   = 1'b1;
                exp[2]   = (i >= 15 && i <= 16 + 2 * len - 2) && !(collided && i > cut);
                exp[1]   = collided && (i == cut + 1);
                exp[0]   = 1'b0;
            end else begin
                exp = {4'h0, 3'b000, !collided};
            end
            check(tag(i, len, cut, collided, pre_coll, v.restart, n), i,
                  {txd_o, tx_en_o, asm_en_o, backoff_o, tx_done_o}, exp);
            coll_i  = (i < n) && (v.hold ? (i >= int'(v.coll_at)) : (i == int'(v.coll_at)));
            start_i = v.restart && (i == 20);
            @(negedge clk);
        end
        coll_i = 1'b0; start_i = 1'b0;
    endtask

    initial begin
        // R1: outputs quiet under reset from time zero
        @(negedge clk);
        check("R1", -1, {txd_o, tx_en_o, asm_en_o, backoff_o, tx_done_o}, 8'h00);
        rst_n = 1'b1;
        // R10: collision while idle does nothing
        coll_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10", k, {txd_o, tx_en_o, asm_en_o, backoff_o, tx_done_o}, 8'h00);
        end
        coll_i = 1'b0;
        for (int vi = 0; vi < 8; vi++) begin
            run_vec(vi);
        end
        // R1: reset in the middle of a frame
        cur_len = 4; cur_seed = 9;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (20) @(negedge clk);
        check("R2", 20, {4'h0, tx_en_o, 3'b000}, 8'h08);
        rst_n = 1'b0;
        #1;
        check("R1", -2, {txd_o, tx_en_o, asm_en_o, backoff_o, tx_done_o}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R10", -3, {txd_o, tx_en_o, asm_en_o, backoff_o, tx_done_o}, 8'h00);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule